// File: doc/BRIEF.md
# Split-Path Direct-Mapped Address Translation Unit

This block turns a virtual address into a physical address for a processor core that keeps separate translation tables for instruction fetch and for data access. Each path owns a small direct-mapped table. Every entry is a pair of registers: a tag register, which holds a virtual page number and a valid flag, and a frame register, which holds a physical page frame and six permission flags. The fetch path uses the execute rights. The data path uses the read and write rights. Each right exists once for supervisor mode and once for user mode. Software loads both registers through a single write port.

A request gives an address, an access kind and the current privilege mode. One clock later the block presents one of four outcomes: hit, no-match, invalid or permission fault. On a hit it also presents the physical address and the granted rights. On a failure it presents an exception code that separates table misses from page faults and the fetch path from the data path, and it copies the faulting virtual address into a held register. Each path can have translation switched off. In that case addresses pass through unchanged with every right granted.

A three-state machine tracks the result register. ST_IDLE means no result is due. ST_GRANT means a hit is presented. ST_DENY means a failure is presented. From any of the three states, a cycle without a request moves to ST_IDLE, a request that hits moves to ST_GRANT, and any other request moves to ST_DENY. The result is valid in ST_GRANT and in ST_DENY.

Top module: `tlb_xlate_unit`

## Requirements
- R1: A request sampled on a rising edge gives rsp_valid high for exactly the following cycle. A cycle without a request gives rsp_valid low in the following cycle.
- R2: The page number is vaddr[31:13] and the table index is vaddr[18:13]. If the stored tag of the indexed entry differs from the full page number, rsp_status is 1 (no-match).
- R3: If the tag equals the page number and the valid flag (flag bit 0 of the tag register) is clear, rsp_status is 2 (invalid).
- R4: A fetch needs supervisor-execute (flag bit 3) in supervisor mode, or user-execute (flag bit 6) in user mode. Without that right, rsp_status is 3 (fault). On a hit, rsp_rights is 3'b100 (bit2 execute, bit1 write, bit0 read).
- R5: Data access uses supervisor-read (bit 1), supervisor-write (bit 2), user-read (bit 4) and user-write (bit 5) according to the mode. A load without read right, or a store without write right, gives status 3. On a hit, rsp_rights is {0, write, read}.
- R6: On a hit, rsp_paddr is the stored frame (bits 31:13) joined with vaddr[12:0].
- R7: req_kind 2 is a fetch and looks up only the instruction table. Every other value is a data access on the data table, where req_kind bit 0 set means write (1 = store, 3 = store, 0 = load).
- R8: rsp_excode is 0 on a hit. It is 1 on fetch no-match or invalid, 2 on data no-match or invalid, 3 on a fetch fault and 4 on a data fault.
- R9: Every failed request copies its vaddr into fault_addr. fault_addr keeps its value at all other times and resets to 0.
- R10: With translation off on the requesting path (xlat_on_fetch or xlat_on_data low), the result is a hit with rsp_paddr equal to vaddr, rsp_rights 3'b111 and rsp_excode 0.
- R11: Reset clears every tag register to zero. After reset, page number 0 gives invalid and every other page gives no-match.
- R12: A write with wr_path 1 targets the instruction table and wr_path 0 the data table. wr_sel 0 writes the tag register {wr_page, wr_flags[0]}. wr_sel 1 writes the frame register {wr_page, wr_flags[6:1]}. The write affects lookups sampled on later edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request this cycle |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 store |
| req_vaddr | input | 32 | Virtual address |
| supervisor | input | 1 | 1 = supervisor mode, 0 = user mode |
| xlat_on_fetch | input | 1 | Translation enabled on the instruction path |
| xlat_on_data | input | 1 | Translation enabled on the data path |
| wr_en | input | 1 | Table write strobe |
| wr_path | input | 1 | 1 = instruction table, 0 = data table |
| wr_sel | input | 1 | 0 = tag register, 1 = frame register |
| wr_index | input | 6 | Entry to write |
| wr_page | input | 19 | Page number or frame to store |
| wr_flags | input | 7 | Bit 0 valid (tag register); bits 6:1 rights (frame register) |
| rsp_valid | output | 1 | Result valid |
| rsp_status | output | 2 | 0 hit, 1 no-match, 2 invalid, 3 fault |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| rsp_rights | output | 3 | Granted rights {exec, write, read} on a hit, else 0 |
| rsp_excode | output | 4 | Exception code |
| fault_addr | output | 32 | Virtual address of the latest failed request |

## Verification
Every outcome is due in the cycle after the rising edge that sampled the request. The status, address, rights, exception code and captured fault address all appear together at that point. Each request pushes its expected outcome into a queue, stamped with the edge count at which it falls due. The monitor samples on the falling edge, compares the front entry only when its stamp matches the current count, and flags any rsp_valid that arrives with no entry due. Table writes go in cycles without a request, so a write always comes before the lookup that depends on it.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    typedef enum logic [1:0] {
        RES_HIT     = 2'd0,
        RES_NOMATCH = 2'd1,
        RES_INVALID = 2'd2,
        RES_FAULT   = 2'd3
    } res_e;

    typedef enum logic [3:0] {
        EXC_NONE  = 4'd0,
        EXC_IMISS = 4'd1,
        EXC_DMISS = 4'd2,
        EXC_IPAGE = 4'd3,
        EXC_DPAGE = 4'd4
    } exc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_DENY  = 2'd2
    } st_e;

    // flag positions inside wr_flags; rights are stored as flags[6:1]
    localparam int unsigned FLAG_W  = 7;
    localparam int unsigned FLAG_SR = 1;
    localparam int unsigned FLAG_SW = 2;
    localparam int unsigned FLAG_SX = 3;
    localparam int unsigned FLAG_UR = 4;
    localparam int unsigned FLAG_UW = 5;
    localparam int unsigned FLAG_UX = 6;

    localparam logic [1:0] KIND_FETCH = 2'd2;

endpackage

// File: rtl/tlbx_store.sv
module tlbx_store
    import tlbx_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned IW      = 6,
    parameter int unsigned PW      = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [IW-1:0]     wr_index,
    input  logic [PW-1:0]     wr_page,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic [IW-1:0]     rd_index,
    output logic [PW-1:0]     rd_tag,
    output logic              rd_vld,
    output logic [PW-1:0]     rd_frame,
    output logic [FLAG_W-2:0] rd_perm
);

    logic [PW-1:0]     tag_q   [ENTRIES];
    logic              vld_q   [ENTRIES];
    logic [PW-1:0]     frame_q [ENTRIES];
    logic [FLAG_W-2:0] perm_q  [ENTRIES];

    // tag registers: cleared by reset so nothing translates until loaded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
                vld_q[i] <= 1'b0;
            end
        end else if (wr_en && !wr_sel) begin
            tag_q[wr_index] <= wr_page;
            vld_q[wr_index] <= wr_flags[0];
        end
    end

    // frame registers: no reset, only read on a validated hit
    always_ff @(posedge clk) begin
        if (wr_en && wr_sel) begin
            frame_q[wr_index] <= wr_page;
            perm_q[wr_index]  <= wr_flags[FLAG_W-1:1];
        end
    end

    assign rd_tag   = tag_q[rd_index];
    assign rd_vld   = vld_q[rd_index];
    assign rd_frame = frame_q[rd_index];
    assign rd_perm  = perm_q[rd_index];

endmodule

// File: rtl/tlbx_judge.sv
module tlbx_judge
    import tlbx_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned OFFB     = 13,
    parameter bit          IS_FETCH = 1'b0
) (
    input  logic              en,
    input  logic              supervisor,
    input  logic              is_write,
    input  logic [AW-1:0]     vaddr,
    input  logic [AW-OFFB-1:0] tag,
    input  logic              vld,
    input  logic [AW-OFFB-1:0] frame,
    input  logic [FLAG_W-2:0] perm,
    output logic [1:0]        status,
    output logic [AW-1:0]     paddr,
    output logic [2:0]        rights
);

    logic rd_ok, wr_ok, ex_ok, need_ok;

    always_comb begin
        rd_ok = supervisor ? perm[FLAG_SR-1] : perm[FLAG_UR-1];
        wr_ok = supervisor ? perm[FLAG_SW-1] : perm[FLAG_UW-1];
        ex_ok = supervisor ? perm[FLAG_SX-1] : perm[FLAG_UX-1];
        if (IS_FETCH) begin
            need_ok = ex_ok;
        end else begin
            need_ok = is_write ? wr_ok : rd_ok;
        end
    end

    always_comb begin
        status = RES_HIT;
        paddr  = '0;
        rights = 3'b000;
        if (!en) begin
            paddr  = vaddr;
            rights = 3'b111;
        end else if (tag != vaddr[AW-1:OFFB]) begin
            status = RES_NOMATCH;
        end else if (!vld) begin
            status = RES_INVALID;
        end else if (!need_ok) begin
            status = RES_FAULT;
        end else begin
            paddr  = {frame, vaddr[OFFB-1:0]};
            rights = IS_FETCH ? 3'b100 : {1'b0, wr_ok, rd_ok};
        end
    end

endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit
    import tlbx_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned PAGE_BITS   = 13,
    parameter int unsigned TLB_ENTRIES = 64,
    localparam int unsigned IW = $clog2(TLB_ENTRIES),
    localparam int unsigned PW = ADDR_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              supervisor,
    input  logic              xlat_on_fetch,
    input  logic              xlat_on_data,
    input  logic              wr_en,
    input  logic              wr_path,
    input  logic              wr_sel,
    input  logic [IW-1:0]     wr_index,
    input  logic [PW-1:0]     wr_page,
    input  logic [FLAG_W-1:0] wr_flags,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_rights,
    output logic [3:0]        rsp_excode,
    output logic [ADDR_W-1:0] fault_addr
);

    logic              is_fetch;
    logic [IW-1:0]     look_idx;

    logic [PW-1:0]     p_tag    [2];
    logic              p_vld    [2];
    logic [PW-1:0]     p_frame  [2];
    logic [FLAG_W-2:0] p_perm   [2];
    logic [1:0]        p_status [2];
    logic [ADDR_W-1:0] p_paddr  [2];
    logic [2:0]        p_rights [2];

    assign is_fetch = (req_kind == KIND_FETCH);
    assign look_idx = req_vaddr[PAGE_BITS+IW-1:PAGE_BITS];

    // path 0 = data table, path 1 = instruction table
    for (genvar p = 0; p < 2; p++) begin : g_path
        tlbx_store #(
            .ENTRIES (TLB_ENTRIES),
            .IW      (IW),
            .PW      (PW)
        ) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_path == 1'(p))),
            .wr_sel   (wr_sel),
            .wr_index (wr_index),
            .wr_page  (wr_page),
            .wr_flags (wr_flags),
            .rd_index (look_idx),
            .rd_tag   (p_tag[p]),
            .rd_vld   (p_vld[p]),
            .rd_frame (p_frame[p]),
            .rd_perm  (p_perm[p])
        );

        tlbx_judge #(
            .AW       (ADDR_W),
            .OFFB     (PAGE_BITS),
            .IS_FETCH (p == 1)
        ) u_judge (
            .en         ((p == 1) ? xlat_on_fetch : xlat_on_data),
            .supervisor (supervisor),
            .is_write   (req_kind[0]),
            .vaddr      (req_vaddr),
            .tag        (p_tag[p]),
            .vld        (p_vld[p]),
            .frame      (p_frame[p]),
            .perm       (p_perm[p]),
            .status     (p_status[p]),
            .paddr      (p_paddr[p]),
            .rights     (p_rights[p])
        );
    end

    logic [1:0]        nx_status;
    logic [ADDR_W-1:0] nx_paddr;
    logic [2:0]        nx_rights;
    logic [3:0]        nx_excode;

    always_comb begin
        nx_status = is_fetch ? p_status[1] : p_status[0];
        nx_paddr  = is_fetch ? p_paddr[1]  : p_paddr[0];
        nx_rights = is_fetch ? p_rights[1] : p_rights[0];
        unique case (nx_status)
            RES_HIT:     nx_excode = EXC_NONE;
            RES_NOMATCH,
            RES_INVALID: nx_excode = is_fetch ? EXC_IMISS : EXC_DMISS;
            default:     nx_excode = is_fetch ? EXC_IPAGE : EXC_DPAGE;
        endcase
    end

    st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_DENY: begin
                if (!req_valid)                 state_d = ST_IDLE;
                else if (nx_status == RES_HIT)  state_d = ST_GRANT;
                else                            state_d = ST_DENY;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_status <= RES_HIT;
            rsp_paddr  <= '0;
            rsp_rights <= 3'b000;
            rsp_excode <= EXC_NONE;
            fault_addr <= '0;
        end else if (req_valid) begin
            rsp_status <= nx_status;
            rsp_paddr  <= nx_paddr;
            rsp_rights <= nx_rights;
            rsp_excode <= nx_excode;
            if (nx_status != RES_HIT) fault_addr <= req_vaddr;
        end
    end

    assign rsp_valid = (state_q != ST_IDLE);

    // ---------------- assertions ----------------
    assert_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_status != RES_HIT) ||
                      (rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));

    assert_deny_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DENY) |-> (rsp_excode != EXC_NONE && rsp_status != RES_HIT));

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_status == RES_HIT) || (fault_addr == $past(req_vaddr)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(fault_addr));

    assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_fetch && !xlat_on_fetch) |=>
            (rsp_status == RES_HIT && rsp_paddr == $past(req_vaddr) && rsp_rights == 3'b111));

endmodule

// File: tb/tlb_xlate_unit_test.sv
`timescale 1ns/1ps
module tlb_xlate_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [31:0] req_vaddr = '0;
    logic        supervisor = 1'b1;
    logic        xlat_on_fetch = 1'b1;
    logic        xlat_on_data = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_path = 1'b0;
    logic        wr_sel = 1'b0;
    logic [5:0]  wr_index = '0;
    logic [18:0] wr_page = '0;
    logic [6:0]  wr_flags = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_rights;
    logic [3:0]  rsp_excode;
    logic [31:0] fault_addr;

    always #2.5 clk = ~clk;

    tlb_xlate_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_vaddr(req_vaddr), .supervisor(supervisor),
        .xlat_on_fetch(xlat_on_fetch), .xlat_on_data(xlat_on_data),
        .wr_en(wr_en), .wr_path(wr_path), .wr_sel(wr_sel), .wr_index(wr_index),
        .wr_page(wr_page), .wr_flags(wr_flags), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_paddr(rsp_paddr), .rsp_rights(rsp_rights),
        .rsp_excode(rsp_excode), .fault_addr(fault_addr)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [1:0]  st;
        logic [31:0] pa;
        logic [2:0]  rt;
        logic [3:0]  ex;
        logic [31:0] fa;
        int          due;
        string       tag;
    } item_t;

    item_t q[$];

    // bench-side shadow of both tables, per R11 / R12
    logic [18:0] m_tag   [2][64];
    logic        m_vld   [2][64];
    logic [18:0] m_frame [2][64];
    logic [6:0]  m_flags [2][64];
    logic [31:0] m_fault = '0;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic item_t predict(input logic [1:0] kind, input logic [31:0] va,
                                      input bit sup, input bit ion, input bit don);
        item_t it;
        int    p;
        int    idx;
        bit    en, ok, rd, wr, ex;
        logic [6:0] f;
        p   = (kind == 2'd2) ? 1 : 0;
        en  = p ? ion : don;
        idx = int'(va[18:13]);
        it.st = 2'd0; it.pa = '0; it.rt = 3'b000; it.ex = 4'd0;
        if (!en) begin
            it.pa = va;
            it.rt = 3'b111;
        end else if (m_tag[p][idx] != va[31:13]) begin
            it.st = 2'd1; it.ex = p ? 4'd1 : 4'd2;
        end else if (!m_vld[p][idx]) begin
            it.st = 2'd2; it.ex = p ? 4'd1 : 4'd2;
        end else begin
            f  = m_flags[p][idx];
            rd = sup ? f[1] : f[4];
            wr = sup ? f[2] : f[5];
            ex = sup ? f[3] : f[6];
            ok = p ? ex : (kind[0] ? wr : rd);
            if (!ok) begin
                it.st = 2'd3; it.ex = p ? 4'd3 : 4'd4;
            end else begin
                it.pa = {m_frame[p][idx], va[12:0]};
                it.rt = p ? 3'b100 : {1'b0, wr, rd};
            end
        end
        return it;
    endfunction

    task automatic req(input logic [1:0] kind, input logic [31:0] va, input bit sup,
                       input bit ion, input bit don, input string tag);
        item_t it;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_vaddr = va; supervisor = sup;
        xlat_on_fetch = ion; xlat_on_data = don; wr_en = 1'b0;
        it = predict(kind, va, sup, ion, don);
        if (it.st != 2'd0) m_fault = va;
        it.fa  = m_fault;
        it.due = cyc + 1;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input bit path, input bit sel, input logic [5:0] idx,
                      input logic [18:0] page, input logic [6:0] flags);
        @(negedge clk);
        req_valid = 1'b0;
        wr_en = 1'b1; wr_path = path; wr_sel = sel; wr_index = idx;
        wr_page = page; wr_flags = flags;
        if (!sel) begin
            m_tag[path][idx] = page; m_vld[path][idx] = flags[0];
        end else begin
            m_frame[path][idx] = page; m_flags[path][idx] = flags;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
    endtask

    // monitor: compare when an expected result falls due
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() != 0 && q[0].due == cyc) begin
                item_t e;
                e = q.pop_front();
                chk(rsp_valid === 1'b1, {e.tag, " valid"}, 32'(rsp_valid), 32'd1);
                chk(rsp_status === e.st && rsp_excode === e.ex,
                    {e.tag, " status/excode"}, {24'd0, rsp_status, 2'd0, rsp_excode},
                    {24'd0, e.st, 2'd0, e.ex});
                chk(rsp_paddr === e.pa && rsp_rights === e.rt,
                    {e.tag, " paddr"}, rsp_paddr ^ {29'd0, rsp_rights}, e.pa ^ {29'd0, e.rt});
                chk(fault_addr === e.fa, {e.tag, " fault_addr"}, fault_addr, e.fa);
            end else if (rsp_valid) begin
                chk(1'b0, "R1 unexpected rsp_valid", 32'd1, 32'd0);
            end
        end
    end

    localparam logic [18:0] VPN_A = 19'h00C45;   // index 5
    localparam logic [18:0] VPN_B = 19'h2A047;   // index 7
    localparam logic [18:0] FRM_A = 19'h7F005;
    localparam logic [18:0] FRM_B = 19'h01234;
    localparam logic [31:0] VA_A  = {VPN_A, 13'h0ABC};
    localparam logic [31:0] VA_B  = {VPN_B, 13'h1FFF};

    initial begin
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 64; i++) begin
                m_tag[p][i] = '0; m_vld[p][i] = 1'b0;
                m_frame[p][i] = '0; m_flags[p][i] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk(fault_addr === 32'd0, "R9 reset fault_addr", fault_addr, 32'd0);

        req(2'd2, 32'h0000_0123, 1, 1, 1, "R11 R3 page0 invalid");
        req(2'd0, 32'h0040_2000, 1, 1, 1, "R11 R2 nomatch after reset");

        wr(0, 0, 6'd5, VPN_A, 7'h01);
        wr(0, 1, 6'd5, FRM_A, 7'h32);          // SR, UR, UW
        req(2'd0, VA_A, 1, 1, 1, "R5 R6 sup load hit");
        req(2'd1, VA_A, 1, 1, 1, "R5 R8 R9 sup store fault");
        req(2'd1, VA_A, 0, 1, 1, "R5 user store hit");
        req(2'd0, {19'h10C45, 13'h0010}, 1, 1, 1, "R2 alias nomatch");
        req(2'd2, VA_A, 1, 1, 1, "R7 fetch uses own table");
        idle();
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R1 idle rsp_valid", 32'(rsp_valid), 32'd0);
        chk(fault_addr === VA_A, "R9 fault_addr held", fault_addr, VA_A);

        wr(1, 0, 6'd5, VPN_A, 7'h01);
        wr(1, 1, 6'd5, FRM_A, 7'h08);          // SX only
        req(2'd2, VA_A, 1, 1, 1, "R4 R12 sup fetch hit");
        req(2'd2, VA_A, 0, 1, 1, "R4 R8 user fetch fault");

        wr(0, 0, 6'd5, VPN_A, 7'h00);
        req(2'd0, VA_A, 1, 1, 1, "R3 R12 invalidated entry");

        wr(0, 0, 6'd7, VPN_B, 7'h01);
        wr(0, 1, 6'd7, FRM_B, 7'h20);          // UW only
        req(2'd3, VA_B, 0, 1, 1, "R7 kind3 is write");
        req(2'd0, VA_B, 0, 1, 1, "R5 user load no read");
        req(2'd0, 32'hDEAD_BEEF, 1, 1, 0, "R10 data pass-through");
        req(2'd2, VA_A, 0, 1, 0, "R4 fetch still translated");
        req(2'd2, 32'h1234_5678, 0, 0, 1, "R10 fetch pass-through");
        idle();

        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule